// File: doc/BRIEF.md
# Ternary Compatible-Equivalence Miter

This block compares a golden and a revised circuit whose signals can take three values: 0, 1 and unknown. Each signal travels on two wires. N pairs of such signals, one from each circuit, go in. The block reports which positions are incompatible and raises one flag if any position is.

The comparison is one-sided. An unknown golden value accepts anything the revised side produces, because the revised design is allowed to resolve an unknown either way. A known golden value accepts only the same known value from the revised side, so a revised unknown is a failure there. The result is registered by default. It captures on a valid strobe and holds between strobes.

The project also provides encoded three-valued AND, OR and NOT gates of parameterised width. With these gates, small golden and revised netlists can be assembled and fed into the miter.

Top module: `tern_compat_miter`

## Requirements
- R1: A signal is coded in two bits, with the upper bit marking unknown. 2'b00 is logic 0 and 2'b01 is logic 1. Both 2'b10 and 2'b11 mean unknown. Position i of a vector uses bits [2i+1:2i].
- R2: When the golden value at a position is unknown (either code), that position never reports a mismatch, whatever the revised value is.
- R3: When the golden value is 0, the position reports a mismatch for a revised 1 or a revised unknown, and reports no mismatch for a revised 0.
- R4: When the golden value is 1, the position reports a mismatch for a revised 0 or a revised unknown, and reports no mismatch for a revised 1.
- R5: The any-mismatch flag equals the OR of all N per-position mismatch bits presented in the same cycle.
- R6: With the output register enabled (the default), both outputs take the comparison of the inputs present at a rising clock edge where valid is high. They show it from that edge onward and keep their value at edges where valid is low.
- R7: A synchronous active-high reset clears the mismatch vector and the flag to 0, and it overrides valid.
- R8: The AND gate returns 0 if either input is 0, and 1 only if both inputs are 1. Otherwise it returns unknown, always as 2'b10, and it accepts 2'b11 as unknown on its inputs.
- R9: The OR gate returns 1 if either input is 1, and 0 only if both inputs are 0. Otherwise it returns 2'b10.
- R10: The NOT gate swaps 0 and 1 and maps either unknown code to 2'b10.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| valid_i | input | 1 | Capture strobe for the output register |
| gold_i | input | 2*N | Encoded golden values, position i at [2i+1:2i] |
| rev_i | input | 2*N | Encoded revised values, same layout |
| mism_o | output | N | Per-position incompatibility bits |
| any_mism_o | output | 1 | OR of all mismatch bits |

## Verification
Every cycle, the bound checker confirms that the flag agrees with the vector and that reset clears both outputs. It also confirms that the outputs hold when valid is low. For each position, after a valid capture, it confirms that a golden unknown gives no mismatch, that a known golden value against a revised unknown gives a mismatch, and that identical known values give no mismatch. Only the bench's scenarios show the following: the full sixteen-entry tables of the gates and the comparator, the canonical unknown code on gate outputs, and a complete De Morgan netlist pair judged compatible under every input mix.

// File: rtl/tcm_pkg.sv
package tcm_pkg;
  typedef logic [1:0] tv_t;

  localparam tv_t TV_ZERO = 2'b00;
  localparam tv_t TV_ONE  = 2'b01;
  localparam tv_t TV_UNK  = 2'b10;

  function automatic logic tv_is_unk(input tv_t v);
    return v[1];
  endfunction

  function automatic tv_t tv_and(input tv_t a, input tv_t b);
    if ((!a[1] && !a[0]) || (!b[1] && !b[0])) return TV_ZERO;
    if (!a[1] && !b[1]) return TV_ONE;
    return TV_UNK;
  endfunction

  function automatic tv_t tv_or(input tv_t a, input tv_t b);
    if ((!a[1] && a[0]) || (!b[1] && b[0])) return TV_ONE;
    if (!a[1] && !b[1]) return TV_ZERO;
    return TV_UNK;
  endfunction

  function automatic tv_t tv_not(input tv_t a);
    if (a[1]) return TV_UNK;
    return {1'b0, ~a[0]};
  endfunction

  // 1 = incompatible; golden unknown accepts anything
  function automatic logic tv_incompat(input tv_t g, input tv_t r);
    if (g[1]) return 1'b0;
    if (r[1]) return 1'b1;
    return g[0] ^ r[0];
  endfunction
endpackage

// File: rtl/tv_gates.sv
module tv_and2 #(
  parameter int W = 1
) (
  input  logic [2*W-1:0] a_i,
  input  logic [2*W-1:0] b_i,
  output logic [2*W-1:0] y_o
);
  import tcm_pkg::*;
  for (genvar i = 0; i < W; i++) begin : g_bit
    assign y_o[2*i +: 2] = tv_and(a_i[2*i +: 2], b_i[2*i +: 2]);
  end
endmodule

module tv_or2 #(
  parameter int W = 1
) (
  input  logic [2*W-1:0] a_i,
  input  logic [2*W-1:0] b_i,
  output logic [2*W-1:0] y_o
);
  import tcm_pkg::*;
  for (genvar i = 0; i < W; i++) begin : g_bit
    assign y_o[2*i +: 2] = tv_or(a_i[2*i +: 2], b_i[2*i +: 2]);
  end
endmodule

module tv_not1 #(
  parameter int W = 1
) (
  input  logic [2*W-1:0] a_i,
  output logic [2*W-1:0] y_o
);
  import tcm_pkg::*;
  for (genvar i = 0; i < W; i++) begin : g_bit
    assign y_o[2*i +: 2] = tv_not(a_i[2*i +: 2]);
  end
endmodule

// File: rtl/tcm_cell.sv
module tcm_cell (
  input  logic [1:0] gold_i,
  input  logic [1:0] rev_i,
  output logic       mism_o
);
  import tcm_pkg::*;
  assign mism_o = tv_incompat(gold_i, rev_i);
endmodule

// File: rtl/tcm_reduce.sv
module tcm_reduce #(
  parameter int N = 4
) (
  input  logic [N-1:0] bits_i,
  output logic         any_o
);
  localparam int HALF = N / 2;
  if (N == 1) begin : g_leaf
    assign any_o = bits_i[0];
  end else begin : g_split
    logic lo_any;
    logic hi_any;
    tcm_reduce #(.N(HALF))     u_lo (.bits_i(bits_i[HALF-1:0]), .any_o(lo_any));
    tcm_reduce #(.N(N - HALF)) u_hi (.bits_i(bits_i[N-1:HALF]), .any_o(hi_any));
    assign any_o = lo_any | hi_any;
  end
endmodule

// File: rtl/tern_compat_miter.sv
module tern_compat_miter #(
  parameter int N       = 4,
  parameter bit REG_OUT = 1'b1
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           valid_i,
  input  logic [2*N-1:0] gold_i,
  input  logic [2*N-1:0] rev_i,
  output logic [N-1:0]   mism_o,
  output logic           any_mism_o
);
  logic [N-1:0] mism_c;
  logic         any_c;

  for (genvar i = 0; i < N; i++) begin : g_pos
    tcm_cell u_cell (
      .gold_i(gold_i[2*i +: 2]),
      .rev_i (rev_i[2*i +: 2]),
      .mism_o(mism_c[i])
    );
  end

  tcm_reduce #(.N(N)) u_red (.bits_i(mism_c), .any_o(any_c));

  if (REG_OUT) begin : g_reg
    always_ff @(posedge clk) begin
      if (rst) begin
        mism_o     <= '0;
        any_mism_o <= 1'b0;
      end else if (valid_i) begin
        mism_o     <= mism_c;
        any_mism_o <= any_c;
      end
    end
  end else begin : g_comb
    assign mism_o     = mism_c;
    assign any_mism_o = any_c;
  end
endmodule

// File: rtl/tcm_checker.sv
module tcm_checker #(
  parameter int N       = 4,
  parameter bit REG_OUT = 1'b1
) (
  input logic           clk,
  input logic           rst,
  input logic           valid_i,
  input logic [2*N-1:0] gold_i,
  input logic [2*N-1:0] rev_i,
  input logic [N-1:0]   mism_o,
  input logic           any_mism_o
);
  AST_ANY_MATCHES_VEC: assert property (@(posedge clk) disable iff (rst)
    any_mism_o == (|mism_o)); // R5

  if (REG_OUT) begin : g_reg
    AST_RESET_CLEARS: assert property (@(posedge clk)
      rst |=> (mism_o == '0) && !any_mism_o); // R7
    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
      !valid_i |=> $stable(mism_o) && $stable(any_mism_o)); // R6
    for (genvar i = 0; i < N; i++) begin : g_pos
      AST_GOLD_UNK_OK: assert property (@(posedge clk) disable iff (rst)
        valid_i && gold_i[2*i+1] |=> !mism_o[i]); // R2
      AST_REV_UNK_BAD: assert property (@(posedge clk) disable iff (rst)
        valid_i && !gold_i[2*i+1] && rev_i[2*i+1] |=> mism_o[i]); // R3
      AST_EXACT_OK: assert property (@(posedge clk) disable iff (rst)
        valid_i && !gold_i[2*i+1] && (gold_i[2*i +: 2] == rev_i[2*i +: 2])
        |=> !mism_o[i]); // R4
    end
  end else begin : g_comb
    for (genvar i = 0; i < N; i++) begin : g_pos
      AST_GOLD_UNK_OK: assert property (@(posedge clk) disable iff (rst)
        gold_i[2*i+1] |-> !mism_o[i]); // R2
      AST_REV_UNK_BAD: assert property (@(posedge clk) disable iff (rst)
        !gold_i[2*i+1] && rev_i[2*i+1] |-> mism_o[i]); // R3
      AST_EXACT_OK: assert property (@(posedge clk) disable iff (rst)
        !gold_i[2*i+1] && (gold_i[2*i +: 2] == rev_i[2*i +: 2]) |-> !mism_o[i]); // R4
    end
  end
endmodule

bind tern_compat_miter tcm_checker #(.N(N), .REG_OUT(REG_OUT)) u_tcm_checker (
  .clk(clk), .rst(rst), .valid_i(valid_i), .gold_i(gold_i), .rev_i(rev_i),
  .mism_o(mism_o), .any_mism_o(any_mism_o)
);

// File: tb/test_tern_compat_miter.sv
`timescale 1ns/1ps
module test_tern_compat_miter;
  localparam int N = 4;
  localparam real HALF_PER = 4.0;

  // index = {a,b}; a = idx[3:2], b = idx[1:0]
  localparam logic [1:0] AND_EXP [16] = '{
    2'b00, 2'b00, 2'b00, 2'b00,
    2'b00, 2'b01, 2'b10, 2'b10,
    2'b00, 2'b10, 2'b10, 2'b10,
    2'b00, 2'b10, 2'b10, 2'b10};
  localparam logic [1:0] OR_EXP [16] = '{
    2'b00, 2'b01, 2'b10, 2'b10,
    2'b01, 2'b01, 2'b01, 2'b01,
    2'b10, 2'b01, 2'b10, 2'b10,
    2'b10, 2'b01, 2'b10, 2'b10};
  localparam logic [1:0] NOT_EXP [4] = '{2'b01, 2'b00, 2'b10, 2'b10};
  // bit {gold,rev}: 1 = incompatible
  localparam logic [15:0] CMP_EXP = 16'b0000_0000_1101_1110;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic valid_i = 1'b0;
  logic [2*N-1:0] gold_i = '0;
  logic [2*N-1:0] rev_i = '0;
  logic [N-1:0] mism_o;
  logic any_mism_o;

  logic [1:0] ga = 2'b00, gb = 2'b00;
  logic [1:0] and_y, or_y, not_y;
  logic [1:0] na, nb, nor_y, dm_y;

  int errors = 0;
  int checks = 0;

  always #(HALF_PER) clk = ~clk;

  tern_compat_miter #(.N(N)) i_tern_compat_miter (
    .clk(clk), .rst(rst), .valid_i(valid_i), .gold_i(gold_i), .rev_i(rev_i),
    .mism_o(mism_o), .any_mism_o(any_mism_o));

  tv_and2 #(.W(1)) u_and (.a_i(ga), .b_i(gb), .y_o(and_y));
  tv_or2  #(.W(1)) u_or  (.a_i(ga), .b_i(gb), .y_o(or_y));
  tv_not1 #(.W(1)) u_not (.a_i(ga), .y_o(not_y));
  // revised netlist: NOT(OR(NOT a, NOT b))
  tv_not1 #(.W(1)) u_na  (.a_i(ga), .y_o(na));
  tv_not1 #(.W(1)) u_nb  (.a_i(gb), .y_o(nb));
  tv_or2  #(.W(1)) u_nor (.a_i(na), .b_i(nb), .y_o(nor_y));
  tv_not1 #(.W(1)) u_dm  (.a_i(nor_y), .y_o(dm_y));

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  initial begin : watchdog
    #(HALF_PER * 2 * 20000);
    errors++;
    $display("FAIL watchdog expired");
    $display("  Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin : main
    logic [N-1:0] exp_v;
    logic [N-1:0] last_v;
    logic last_a;
    // reset state R7
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(mism_o == '0 && !any_mism_o, "R7 reset state", {mism_o, any_mism_o}, 0);
    rst = 1'b0;

    // gate sweep R8 R9 R10 R1
    for (int i = 0; i < 16; i++) begin
      ga = i[3:2]; gb = i[1:0];
      #1;
      chk(and_y == AND_EXP[i], "R8 and", and_y, AND_EXP[i]);
      chk(or_y == OR_EXP[i], "R9 or", or_y, OR_EXP[i]);
      chk(not_y == NOT_EXP[i/4], "R10 not", not_y, NOT_EXP[i/4]);
    end

    // miter sweep: position p gets combo (k + 4p) mod 16; R2 R3 R4 R5 R6
    last_v = '0; last_a = 1'b0;
    for (int k = 0; k < 16; k++) begin
      @(negedge clk);
      exp_v = '0;
      for (int p = 0; p < N; p++) begin
        int c;
        c = (k + 4 * p) % 16;
        gold_i[2*p +: 2] = 2'(c >> 2);
        rev_i[2*p +: 2]  = 2'(c & 3);
        exp_v[p] = CMP_EXP[c];
      end
      valid_i = 1'b1;
      @(negedge clk);
      chk(mism_o == exp_v, "R2/R3/R4 compat vector", mism_o, exp_v);
      chk(any_mism_o == (|exp_v), "R5 any flag", any_mism_o, |exp_v);
      last_v = exp_v; last_a = |exp_v;
    end

    // hold with valid low R6
    valid_i = 1'b0;
    gold_i = {N{2'b00}};
    rev_i  = {N{2'b01}};
    @(negedge clk);
    @(negedge clk);
    chk(mism_o == last_v && any_mism_o == last_a, "R6 hold when idle",
        {mism_o, any_mism_o}, {last_v, last_a});

    // all golden unknown, revised arbitrary R2
    gold_i = {N{2'b11}};
    rev_i  = {2'b01, 2'b00, 2'b10, 2'b11};
    valid_i = 1'b1;
    @(negedge clk);
    chk(mism_o == '0 && !any_mism_o, "R2 all golden unknown", {mism_o, any_mism_o}, 0);

    // netlist pair: golden AND vs revised De Morgan; R5 R8
    for (int i = 0; i < 9; i++) begin
      logic [1:0] codes [3];
      codes = '{2'b00, 2'b01, 2'b11};
      ga = codes[i / 3]; gb = codes[i % 3];
      #1;
      gold_i = {{(N-1){2'b10}}, and_y};
      rev_i  = {{(N-1){2'b01}}, dm_y};
      @(negedge clk);
      chk(!any_mism_o && mism_o == '0, "R5 netlist pair compatible",
          {mism_o, any_mism_o}, 0);
    end

    // single position: golden 1 vs revised unknown at top position R4 R5
    gold_i = {2'b01, 2'b00, 2'b01, 2'b10};
    rev_i  = {2'b11, 2'b00, 2'b01, 2'b00};
    @(negedge clk);
    chk(mism_o == 4'b1000, "R4 golden one vs revised unknown", mism_o, 4'b1000);
    chk(any_mism_o, "R5 flag from single position", any_mism_o, 1);

    // golden 0 vs revised 1 R3
    gold_i = {2'b10, 2'b00, 2'b10, 2'b10};
    rev_i  = {2'b00, 2'b01, 2'b00, 2'b00};
    @(negedge clk);
    chk(mism_o == 4'b0100, "R3 golden zero vs revised one", mism_o, 4'b0100);

    // reset overrides valid R7
    rst = 1'b1;
    @(negedge clk);
    chk(mism_o == '0 && !any_mism_o, "R7 reset over valid", {mism_o, any_mism_o}, 0);
    rst = 1'b0;
    valid_i = 1'b0;
    @(negedge clk);

    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule